// File: doc/BRIEF.md
# Serial Latch Output Expander

This block produces a byte of board control lines, such as chip selects, a mute line, a PLL enable and a rate select, through an external 8-bit serial-in, parallel-out register. It keeps a shadow copy of the byte that is on the external outputs, and the parallel `shadow_q` output shows that copy to other logic.

A requester offers work on a valid/ready handshake. A request either replaces the whole byte or changes one bit. For a one-bit request the block reads the shadow, changes the chosen bit and sends all eight bits again. Each transfer drives the shift clock low first. It then puts each bit on the data line, most significant first, and raises and lowers the shift clock. At the end it gives one high pulse on the latch line, which stays low the rest of the time, so the external register copies the byte to its outputs. The shift-clock half-period is set by the `DIV` parameter, counted in system clock cycles.

Top module: `latch_expander`

## Requirements
- R1: Each transfer puts exactly eight bits on `ser_data`, most significant bit first. The external register takes each bit on a rising edge of `ser_clk`, and `ser_data` does not change while `ser_clk` is high.
- R2: `ser_clk` is low whenever the block is idle and when a transfer starts. Each high and each low level of `ser_clk` lasts at least `DIV` system clock cycles (default 4).
- R3: `latch_en` stays low while bits are being shifted. After the eighth bit it goes high for exactly one pulse, then returns low before `busy` falls. It is never high while `ser_clk` is high.
- R4: A whole-byte request (`req_kind` = 0) loads `req_data` into the shadow and sends that byte.
- R5: A one-bit request (`req_kind` = 1) sets shadow bit `req_bit_idx` to `req_bit_val`, with bit 0 the least significant, leaves the other seven bits unchanged, and sends the whole updated byte.
- R6: After reset the shadow is 0xFC, `ser_clk`, `latch_en` and `busy` are low, and `req_ready` is high.
- R7: `req_ready` is the inverse of `busy`. A request offered while `busy` is high is ignored: the shadow does not change and no extra transfer starts.
- R8: On the cycle after a request is accepted, `busy` is high and `shadow_q` already shows the new byte. `busy` stays high until the latch pulse has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can accept a request |
| req_kind | input | 1 | 0 = whole byte, 1 = single bit |
| req_data | input | 8 | Byte for a whole-byte request |
| req_bit_idx | input | 3 | Bit chosen by a single-bit request |
| req_bit_val | input | 1 | New value of the chosen bit |
| ser_data | output | 1 | Serial data to the external register |
| ser_clk | output | 1 | Shift clock; the rising edge captures a bit |
| latch_en | output | 1 | Latch strobe, high pulse at the end of a transfer |
| busy | output | 1 | A transfer is in progress |
| shadow_q | output | 8 | Current shadow copy of the external outputs |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of a transfer. The bench accepts one whole-byte write, then holds `req_valid` high with a different byte for several cycles while `busy` is high, and releases it before the transfer ends. It then checks that the latched byte, the shadow and the count of latch pulses all match a single transfer. The other stimulus sends all 256 byte values and every bit index with both bit values. A monitor captures each serial frame on the rising edges of `ser_clk` and measures every shift-clock level against `DIV`.

// File: rtl/lexp_pkg.sv
package lexp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_HIGH   = 3'd2,
    ST_STROBE = 3'd3,
    ST_TAIL   = 3'd4
  } shift_state_e;

  typedef enum logic {
    REQ_BYTE = 1'b0,
    REQ_BIT  = 1'b1
  } req_kind_e;
endpackage

// File: rtl/lexp_rst_sync.sv
module lexp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/lexp_tick.sv
module lexp_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_end
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run || cnt_q == LAST) cnt_d = '0;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign phase_end = run && (cnt_q == LAST);
endmodule

// File: rtl/lexp_shadow.sv
module lexp_shadow #(
  parameter int               W       = 8,
  parameter logic [W-1:0]     RST_VAL = 8'hFC,
  parameter int               IDXW    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            kind,
  input  logic [W-1:0]    wr_data,
  input  logic [IDXW-1:0] bit_idx,
  input  logic            bit_val,
  output logic [W-1:0]    shadow_q,
  output logic [W-1:0]    shadow_nxt
);
  import lexp_pkg::*;

  always_comb begin
    if (kind == REQ_BYTE) begin
      shadow_nxt = wr_data;
    end else begin
      for (int i = 0; i < W; i++) begin
        shadow_nxt[i] = (bit_idx == IDXW'(i)) ? bit_val : shadow_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shadow_q <= RST_VAL;
    else if (accept) shadow_q <= shadow_nxt;
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accept) |-> $stable(shadow_q)) else $error("shadow moved without accept"); // R7
endmodule

// File: rtl/lexp_shifter.sv
module lexp_shifter #(
  parameter int W   = 8,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] frame,
  input  logic         phase_end,
  output logic         run,
  output logic         ser_data,
  output logic         ser_clk,
  output logic         latch_en
);
  import lexp_pkg::*;

  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam int RW = $clog2(DIV + 1) + 1;

  shift_state_e  state_q, state_d;
  logic [W-1:0]  sr_q, sr_d;
  logic [BW-1:0] bit_q, bit_d;

  always_comb begin
    state_d = state_q;
    sr_d    = sr_q;
    bit_d   = bit_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SETUP;
          sr_d    = frame;
          bit_d   = BW'(W - 1);
        end
      end
      ST_SETUP: begin
        if (phase_end) state_d = ST_HIGH;
      end
      ST_HIGH: begin
        if (phase_end) begin
          if (bit_q == '0) begin
            state_d = ST_STROBE;
          end else begin
            state_d = ST_SETUP;
            bit_d   = bit_q - 1'b1;
            sr_d    = {sr_q[W-2:0], 1'b0};
          end
        end
      end
      ST_STROBE: begin
        if (phase_end) state_d = ST_TAIL;
      end
      ST_TAIL: begin
        if (phase_end) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sr_q    <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      sr_q    <= sr_d;
      bit_q   <= bit_d;
    end
  end

  assign run      = (state_q != ST_IDLE);
  assign ser_clk  = (state_q == ST_HIGH);
  assign latch_en = (state_q == ST_STROBE);
  assign ser_data = sr_q[W-1];

  // Checker state: shift-clock level lengths, rising edges per frame, data stability.
  logic          sclk_prev;
  logic          sdata_prev;
  logic [RW-1:0] level_len;
  logic [BW:0]   rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev  <= 1'b0;
      sdata_prev <= 1'b0;
      level_len  <= RW'(DIV);
      rises      <= '0;
    end else begin
      sclk_prev  <= ser_clk;
      sdata_prev <= ser_data;
      if (ser_clk != sclk_prev)       level_len <= RW'(1);
      else if (level_len < RW'(DIV))  level_len <= level_len + 1'b1;
      if (!run)                       rises <= '0;
      else if (ser_clk && !sclk_prev) rises <= rises + 1'b1;
    end
  end

  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk != sclk_prev) |-> (level_len >= RW'(DIV))) else $error("short clock level"); // R2
  AST_EIGHT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && !$past(latch_en)) |-> (rises == (BW+1)'(W))) else $error("bit count"); // R1
  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && sclk_prev) |-> (ser_data == sdata_prev)) else $error("data moved"); // R1
endmodule

// File: rtl/latch_expander.sv
module latch_expander #(
  parameter int           W       = 8,
  parameter int           DIV     = 4,
  parameter logic [W-1:0] RST_VAL = 8'hFC,
  parameter int           IDXW    = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_kind,
  input  logic [W-1:0]    req_data,
  input  logic [IDXW-1:0] req_bit_idx,
  input  logic            req_bit_val,
  output logic            ser_data,
  output logic            ser_clk,
  output logic            latch_en,
  output logic            busy,
  output logic [W-1:0]    shadow_q
);
  logic rst_n_s;
  logic accept;
  logic run;
  logic phase_end;
  logic [W-1:0] shadow_nxt;

  lexp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign busy      = run;
  assign req_ready = !run;
  assign accept    = req_valid && req_ready;

  lexp_shadow #(.W(W), .RST_VAL(RST_VAL), .IDXW(IDXW)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .accept     (accept),
    .kind       (req_kind),
    .wr_data    (req_data),
    .bit_idx    (req_bit_idx),
    .bit_val    (req_bit_val),
    .shadow_q   (shadow_q),
    .shadow_nxt (shadow_nxt)
  );

  lexp_tick #(.DIV(DIV)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .run       (run),
    .phase_end (phase_end)
  );

  lexp_shifter #(.W(W), .DIV(DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (accept),
    .frame     (shadow_nxt),
    .phase_end (phase_end),
    .run       (run),
    .ser_data  (ser_data),
    .ser_clk   (ser_clk),
    .latch_en  (latch_en)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> (!ser_clk && !latch_en)) else $error("lines active while idle"); // R2
  AST_LATCH_NOT_WITH_CLK: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(ser_clk && latch_en)) else $error("latch during shift clock high"); // R3
  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(busy) |-> $past(req_valid)) else $error("busy without request"); // R8
  AST_BUSY_SHADOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && $past(busy)) |-> $stable(shadow_q)) else $error("shadow changed while busy"); // R7
  AST_LATCH_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(busy) |-> !latch_en) else $error("busy fell with latch high"); // R3
endmodule

// File: tb/tb_latch_expander.sv
`timescale 1ns/1ps
module tb_latch_expander;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_kind = 1'b0;
  logic [7:0] req_data = 8'h00;
  logic [2:0] req_bit_idx = 3'd0;
  logic req_bit_val = 1'b0;
  logic req_ready, ser_data, ser_clk, latch_en, busy;
  logic [7:0] shadow_q;

  always #4 clk = ~clk;

  latch_expander #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_data(req_data), .req_bit_idx(req_bit_idx),
    .req_bit_val(req_bit_val), .ser_data(ser_data), .ser_clk(ser_clk),
    .latch_en(latch_en), .busy(busy), .shadow_q(shadow_q)
  );

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_sh;

  // Serial monitor
  logic [7:0] cap = 8'h00;
  int nbits = 0;
  int last_bits = 0;
  logic [7:0] last_frame = 8'h00;
  int frames = 0;
  int latch_during_clk = 0;

  always @(posedge ser_clk) begin
    cap = {cap[6:0], ser_data};
    nbits = nbits + 1;
    if (latch_en) latch_during_clk = latch_during_clk + 1;
  end

  always @(posedge latch_en) begin
    last_frame = cap;
    last_bits = nbits;
    nbits = 0;
    frames = frames + 1;
  end

  // Shift-clock level length measured at falling system-clock edges
  int run_len = 0;
  int min_len = 1000;
  logic prev_sclk = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_clk != prev_sclk) begin
        if (run_len < min_len) min_len = run_len;
        run_len = 1;
      end else begin
        run_len = run_len + 1;
      end
      prev_sclk = ser_clk;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic finish_transfer(input logic [7:0] expect_byte, input int frames_before);
    while (busy) @(negedge clk);
    chk(frames == frames_before + 1, "R3 one latch pulse", frames, frames_before + 1);
    chk(last_bits == 8, "R1 eight bits", last_bits, 8);
    chk(last_frame == expect_byte, "R1 MSB-first frame", last_frame, expect_byte);
    chk(shadow_q == expect_byte, "R4/R5 shadow", shadow_q, expect_byte);
    chk(!latch_en && !ser_clk && req_ready, "R3 lines idle after transfer",
        {latch_en, ser_clk, req_ready}, 3'b001);
  endtask

  task automatic send(input logic kind, input logic [7:0] data,
                      input logic [2:0] idx, input logic val);
    int fb;
    fb = frames;
    if (kind) exp_sh = (exp_sh & ~(8'h01 << idx)) | ({7'd0, val} << idx);
    else      exp_sh = data;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_data = data;
    req_bit_idx = idx; req_bit_val = val;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R8 busy after accept", {busy, req_ready}, 2'b10);
    chk(shadow_q == exp_sh, "R8 shadow visible next cycle", shadow_q, exp_sh);
    chk(!ser_clk && !latch_en, "R2 clock low at start", {ser_clk, latch_en}, 0);
    finish_transfer(exp_sh, fb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R6 reset state
    chk(shadow_q == 8'hFC, "R6 shadow reset", shadow_q, 8'hFC);
    chk(!ser_clk && !latch_en && !busy && req_ready, "R6 lines after reset",
        {ser_clk, latch_en, busy, req_ready}, 4'b0001);
    exp_sh = 8'hFC;

    // R5 single-bit updates starting from reset value
    for (int i = 0; i < 8; i++) begin
      send(1'b1, 8'h00, 3'(i), 1'b1);
      send(1'b1, 8'h00, 3'(i), 1'b0);
    end

    // R4 exhaustive whole-byte writes
    for (int b = 0; b < 256; b++) send(1'b0, 8'(b), 3'd0, 1'b0);

    // R5 single-bit updates on a mixed pattern
    send(1'b0, 8'h5A, 3'd0, 1'b0);
    for (int i = 0; i < 8; i++) send(1'b1, 8'hFF, 3'(7 - i), ~exp_sh[7 - i]);

    // R7 requests while busy are ignored
    begin
      int fb;
      fb = frames;
      exp_sh = 8'hA5;
      @(negedge clk);
      req_valid = 1'b1; req_kind = 1'b0; req_data = 8'hA5;
      @(negedge clk);
      req_data = 8'h3C;
      for (int k = 0; k < 10; k++) begin
        chk(!req_ready, "R7 ready low while busy", req_ready, 0);
        @(negedge clk);
      end
      req_valid = 1'b0;
      chk(shadow_q == 8'hA5, "R7 shadow unchanged by busy request", shadow_q, 8'hA5);
      finish_transfer(8'hA5, fb);
      repeat (DIV * 20) @(negedge clk);
      chk(frames == fb + 1, "R7 no extra transfer", frames, fb + 1);
      chk(shadow_q == 8'hA5, "R7 shadow still held", shadow_q, 8'hA5);
    end

    chk(min_len >= DIV, "R2 shift clock level length", min_len, DIV);
    chk(latch_during_clk == 0, "R3 latch low on clock rise", latch_during_clk, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule